// File: doc/BRIEF.md
# Recursive Approximate Multiplier

This block is a purely combinational unsigned multiplier that trades a small, predictable error for a smaller and faster circuit. Its smallest element is a 2x2 multiplier cell with a three-bit result. The cell is exact for fifteen of the sixteen input pairs. When both inputs are 3 it returns 7 instead of 9, so the cell never needs a fourth output bit.

Wider multipliers are built by recursion. A stage of width 2m splits each operand into a high half and a low half. It forms four m x m sub-products with smaller stages and merges them exactly as HH*2^(2m) + (HL+LH)*2^m + LL. Every error therefore comes from the 2x2 cells and none from the merging. The operand width is a parameter: a power of two, at least 2, and 16 by default.

A consequence of the exact merging is a closed form for the result. Call the operand bit pairs [2i+1:2i] "digits". Each digit pair (i of A, j of B) where both digits are 3 lowers the product by exactly 2*4^(i+j). No other pair changes it.

Top module: `approx_rmul`

## Requirements
- R1: A single nonzero digit of A at digit position i and a single nonzero digit of B at position j give da*db*4^(i+j) whenever the two digits are not both 3.
- R2: When a digit 3 of A meets a digit 3 of B at positions i and j, with all other digits zero, the product is 7*4^(i+j).
- R3: For any operands, the product equals the recursive rule: HH*2^(2m) + (HL+LH)*2^m + LL at every level, with the 2x2 cell as the base.
- R4: If either operand is zero, the product is zero.
- R5: If no digit of A equal to 3 meets a digit of B equal to 3, the product is the exact product A*B.
- R6: The exact product minus the output equals 2 times the sum of 4^(i+j) over all pairs (i, j) where digit i of A and digit j of B are both 3. Hence the output never exceeds the exact product.
- R7: With both operands all ones, the output is (2^N-1)^2 - 2*((4^(N/2)-1)/3)^2. For N=16 this is 3340428175.
- R8: Swapping the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | Unsigned multiplicand |
| opnd_b | input | N | Unsigned multiplier |
| product | output | 2N | Approximate unsigned product |

## Verification
The checks assume that both operands carry known values. Until the first operand values are driven, no check is made. All checks compare the output with values computed from the operand ports alone. Examples are the closed-form shortfall from the 3-meets-3 digit pairs and the exactness rule when no such pair exists. The stimulus drives both operands together on one clock edge. It samples the product half a period later, so the comparison always sees a settled, fully known output.

// File: rtl/arm_pkg.sv
package arm_pkg;

    // Width of the base cell operand and of its result.
    localparam int CELL_IN_W  = 2;
    localparam int CELL_OUT_W = 3;

    typedef logic [CELL_IN_W-1:0]  digit_t;
    typedef logic [CELL_OUT_W-1:0] cell_prod_t;

    // Partial-product terms of the base cell before they are packed.
    typedef struct packed {
        logic b2;
        logic b1;
        logic b0;
    } cell_terms_t;

    function automatic bit is_pow2_ge2(input int w);
        return (w >= 2) && ((w & (w - 1)) == 0);
    endfunction

endpackage

// File: rtl/arm_cell2.sv
module arm_cell2
    import arm_pkg::*;
(
    input  digit_t     x,
    input  digit_t     y,
    output cell_prod_t z
);

    cell_terms_t terms_d;

    // The middle bit uses OR instead of XOR.
    // This maps 3x3 to 3'b111 and leaves the other 15 pairs exact.
    always_comb begin
        terms_d.b0 = x[0] & y[0];
        terms_d.b1 = (x[1] & y[0]) | (x[0] & y[1]);
        terms_d.b2 = x[1] & y[1];
    end

    assign z = {terms_d.b2, terms_d.b1, terms_d.b0};

endmodule

// File: rtl/arm_merge.sv
module arm_merge #(
    parameter int M = 2
) (
    input  logic [2*M-1:0] hh,
    input  logic [2*M-1:0] hl,
    input  logic [2*M-1:0] lh,
    input  logic [2*M-1:0] ll,
    output logic [4*M-1:0] sum
);

    localparam int OUT_W = 4 * M;
    localparam int MID_W = 2 * M + 1;

    typedef struct packed {
        logic [MID_W-1:0] mid;
        logic [OUT_W-1:0] outer;
        logic [OUT_W-1:0] total;
    } merge_t;

    merge_t m_d;

    // The outer terms do not overlap, so a concatenation places them.
    // The cross terms are added and then shifted by M.
    // Because every cell is at or below the exact product, the total fits in OUT_W.
    always_comb begin
        m_d.mid   = {1'b0, hl} + {1'b0, lh};
        m_d.outer = {hh, ll};
        m_d.total = m_d.outer + (OUT_W'(m_d.mid) << M);
    end

    assign sum = m_d.total;

endmodule

// File: rtl/arm_node.sv
module arm_node #(
    parameter int W = 2
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    generate
        if (W == 2) begin : g_leaf
            logic [2:0] cell_z;
            arm_cell2 u_cell (
                .x (a),
                .y (b),
                .z (cell_z)
            );
            assign p = {1'b0, cell_z};
        end else begin : g_split
            localparam int M = W / 2;
            logic [2*M-1:0] p_hh, p_hl, p_lh, p_ll;

            arm_node #(.W(M)) u_hh (.a(a[W-1:M]), .b(b[W-1:M]), .p(p_hh));
            arm_node #(.W(M)) u_hl (.a(a[W-1:M]), .b(b[M-1:0]), .p(p_hl));
            arm_node #(.W(M)) u_lh (.a(a[M-1:0]), .b(b[W-1:M]), .p(p_lh));
            arm_node #(.W(M)) u_ll (.a(a[M-1:0]), .b(b[M-1:0]), .p(p_ll));

            arm_merge #(.M(M)) u_merge (
                .hh  (p_hh),
                .hl  (p_hl),
                .lh  (p_lh),
                .ll  (p_ll),
                .sum (p)
            );
        end
    endgenerate

endmodule

// File: rtl/approx_rmul.sv
module approx_rmul
    import arm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   opnd_a,
    input  logic [N-1:0]   opnd_b,
    output logic [2*N-1:0] product
);

    generate
        if (!is_pow2_ge2(N)) begin : g_bad_width
            $error("approx_rmul: N must be a power of two and at least 2");
        end
    endgenerate

    arm_node #(.W(N)) u_root (
        .a (opnd_a),
        .b (opnd_b),
        .p (product)
    );

endmodule

// File: rtl/arm_chk.sv
module arm_chk #(
    parameter int N = 16
) (
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] p
);

    localparam int PW = 2 * N;
    localparam int ND = N / 2;

    logic [PW-1:0] exact_v;
    logic [PW-1:0] shortfall_v;
    logic          any_hit_v;
    logic [PW-1:0] ones_v;

    always_comb begin
        exact_v     = PW'(a) * PW'(b);
        shortfall_v = '0;
        any_hit_v   = 1'b0;
        ones_v      = '0;
        for (int i = 0; i < ND; i++) begin
            for (int j = 0; j < ND; j++) begin
                ones_v = ones_v + (PW'(2) << (2 * (i + j)));
                if (a[2*i +: 2] == 2'b11 && b[2*j +: 2] == 2'b11) begin
                    shortfall_v = shortfall_v + (PW'(2) << (2 * (i + j)));
                    any_hit_v   = 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_zero_R4: assert (!((a == '0) || (b == '0)) || (p == '0));
            assert_exact_R5: assert (any_hit_v || (p == exact_v));
            assert_shortfall_R6: assert ((exact_v - p) == shortfall_v);
            assert_bound_R6: assert (p <= exact_v);
            assert_allones_R7: assert (!((&a) && (&b)) || (p == (exact_v - ones_v)));
        end
    end

endmodule

bind approx_rmul arm_chk #(.N(N)) u_arm_chk (
    .a (opnd_a),
    .b (opnd_b),
    .p (product)
);

// File: tb/test_approx_rmul.sv
`timescale 1ns/1ps
module test_approx_rmul;

    localparam int N  = 16;
    localparam int PW = 2 * N;
    localparam int ND = N / 2;

    logic          clk = 1'b0;
    logic [N-1:0]  a_in = '0;
    logic [N-1:0]  b_in = '0;
    logic [PW-1:0] prod_out;
    int            n_vec = 0;
    int            n_bad = 0;
    logic [31:0]   rng = 32'h1234_5679;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    approx_rmul #(.N(N)) i_approx_rmul (
        .opnd_a  (a_in),
        .opnd_b  (b_in),
        .product (prod_out)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y, input int w);
        logic [63:0] hh, hl, lh, ll;
        logic [31:0] mask;
        int m;
        if (w == 2) return (x[1:0] == 2'd3 && y[1:0] == 2'd3) ? 64'd7 : 64'(x[1:0] * y[1:0]);
        m    = w / 2;
        mask = (32'd1 << m) - 32'd1;
        hh = ref_mul(x >> m, y >> m, m);
        hl = ref_mul(x >> m, y & mask, m);
        lh = ref_mul(x & mask, y >> m, m);
        ll = ref_mul(x & mask, y & mask, m);
        return (hh << w) + ((hl + lh) << m) + ll;
    endfunction

    function automatic logic [PW-1:0] shortfall(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [PW-1:0] s = '0;
        for (int i = 0; i < ND; i++)
            for (int j = 0; j < ND; j++)
                if (x[2*i +: 2] == 2'b11 && y[2*j +: 2] == 2'b11)
                    s = s + (PW'(2) << (2 * (i + j)));
        return s;
    endfunction

    function automatic logic [N-1:0] strip3(input logic [N-1:0] x);
        logic [N-1:0] r = x;
        for (int i = 0; i < ND; i++)
            if (r[2*i +: 2] == 2'b11) r[2*i +: 2] = 2'b10;
        return r;
    endfunction

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(posedge clk);
        a_in = x;
        b_in = y;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h actual=%0d expected=%0d", req, a_in, b_in, got, exp);
        end
    endtask

    // R4: a zero operand on either side, and both zero at the start
    task automatic t_zero();
        apply('0, '0);
        check("R4", prod_out, '0);
        apply(16'hFFFF, '0);
        check("R4", prod_out, '0);
        apply('0, 16'hBEEF);
        check("R4", prod_out, '0);
    endtask

    // R1 and R2: one digit on each side, at several digit positions
    task automatic t_cells();
        int pos[3][2] = '{'{0, 0}, '{3, 5}, '{7, 7}};
        for (int k = 0; k < 3; k++) begin
            for (int da = 0; da < 4; da++) begin
                for (int db = 0; db < 4; db++) begin
                    logic [PW-1:0] cv;
                    cv = (da == 3 && db == 3) ? PW'(7) : PW'(da * db);
                    apply(N'(da) << (2 * pos[k][0]), N'(db) << (2 * pos[k][1]));
                    if (da == 3 && db == 3)
                        check("R2", prod_out, cv << (2 * (pos[k][0] + pos[k][1])));
                    else
                        check("R1", prod_out, cv << (2 * (pos[k][0] + pos[k][1])));
                end
            end
        end
    endtask

    // R7: both operands all ones
    task automatic t_allones();
        apply(16'hFFFF, 16'hFFFF);
        check("R7", prod_out, PW'(64'd3340428175));
        apply(16'h000F, 16'h000F);
        check("R7", prod_out, PW'(175));
    endtask

    // R5: no 3-meets-3 digit pair, so the product is exact
    task automatic t_exact();
        for (int k = 0; k < 60; k++) begin
            logic [N-1:0] x, y;
            next_rng();
            x = rng[15:0];
            y = rng[31:16];
            if (k % 2 == 0) x = strip3(x);
            else            y = strip3(y);
            apply(x, y);
            check("R5", prod_out, PW'(x) * PW'(y));
        end
    endtask

    // R3 and R6: arbitrary operands against the recursive model and the closed form
    task automatic t_random();
        for (int k = 0; k < 200; k++) begin
            logic [N-1:0] x, y;
            next_rng();
            x = rng[15:0];
            y = rng[31:16];
            apply(x, y);
            check("R3", prod_out, PW'(ref_mul(32'(x), 32'(y), N)));
            check("R6", prod_out, (PW'(x) * PW'(y)) - shortfall(x, y));
        end
    endtask

    // R8: swapping the operands gives the same product
    task automatic t_swap();
        for (int k = 0; k < 40; k++) begin
            logic [N-1:0] x, y;
            logic [PW-1:0] first;
            next_rng();
            x = rng[15:0] | 16'h0303;
            y = rng[31:16];
            apply(x, y);
            first = prod_out;
            apply(y, x);
            check("R8", prod_out, first);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_zero();
        t_cells();
        t_allones();
        t_exact();
        t_random();
        t_swap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule